// File: doc/BRIEF.md
# Core-Voltage Reference Ramp and Power-Good Sequencer

This block is the digital side of the reference path of a core-voltage buck regulator. It turns a 5-bit voltage-identification code into a target in millivolts. It then moves a millivolt reference toward that target one clock tick at a time, and an external converter turns the reference into the analog setpoint.

After each start the reference climbs at a slow rate. Once it has reached 90 percent of the target it switches for good to a rate twenty times faster. The fast rate also governs every later code change, up or down. The last step always lands exactly on the target.

The same block raises a power-good flag from a digitized sample of the output voltage. The flag uses separate rising and falling thresholds and a rising delay counted in clock ticks. It is forced low by an external shutdown request and whenever the regulator is not running.

Top module: `vid_ref_seq`

## Requirements
- R1: For a code whose bit 4 is 1 and whose low nibble n is 0 to 14, the target is 925 + 25*(14-n) mV. Code 11110 gives 925 mV and code 10000 gives 1275 mV.
- R2: For a code whose bit 4 is 0 and whose low nibble n is 0 to 14, the target is 1300 + 50*(14-n) mV. Code 01110 gives 1300 mV and code 00000 gives 2000 mV.
- R3: Codes 11111 and 01111 give a 0 mV target. Code 11111 is also what a fully unconnected code input reads as, since open inputs are pulled to 1.
- R4: After a start, the reference rises by SLOW_STEP per clock, and `fast_mode` stays low, until an edge at which the reference already held is at least 90 percent of the target.
- R5: At that edge `fast_mode` goes high and stays high while running. From the following edge on, the reference moves by FAST_STEP per clock in both directions, including after code changes.
- R6: The reference never passes the target. A step that would reach or cross it lands exactly on the target, both upward and downward.
- R7: While reset is asserted, or while `en` or `supply_ok` is low, the reference goes to 0 and `fast_mode` to 0 at the next edge. A later start therefore ramps again from 0 at the slow rate.
- R8: `pgood` rises at the PG_DELAY-th consecutive rising edge at which `vsense_mv` is above PG_RISE_MV (875 mV exactly does not count). Any edge without that condition restarts the count while `pgood` is low.
- R9: `pgood` falls at the first edge at which `vsense_mv` is below PG_FALL_MV. Between the two thresholds (825 mV included) a high `pgood` stays high.
- R10: `pgood` is low one edge after `fault_shdn` is high or after the regulator stops running, and its delay restarts from zero afterwards.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; one ramp step per rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| en | input | 1 | Regulator enable |
| supply_ok | input | 1 | Supply above its undervoltage threshold |
| fault_shdn | input | 1 | Shutdown request from over-temperature or over-current logic |
| vid | input | 5 | Voltage-identification code |
| vsense_mv | input | MVW | Digitized output voltage in mV |
| target_mv | output | MVW | Decoded target in mV (combinational) |
| ref_mv | output | MVW | Ramped reference in mV |
| fast_mode | output | 1 | High once the fast slew rate is in force |
| pgood | output | 1 | Power-good flag |

## Verification
`target_mv` is combinational, so the bench checks it in the same cycle it sets `vid`. `ref_mv` and `fast_mode` change one edge after the inputs are sampled. The bench drives inputs on the falling edge, steps a model written from R4 to R7 on each rising edge, and compares the model with the design at the next falling edge. The 90 percent switch is therefore checked at the exact edge where it happens. For `pgood`, the bench counts PG_DELAY-1 edges and expects the flag still low, then checks that it is high after one more edge. A fall is expected one edge after `vsense_mv` drops below the threshold, and a forced low one edge after the fault or the disable.

// File: rtl/vid_ref_seq.sv
module vid_ref_seq #(
  parameter int MVW        = 12,
  parameter int SLOW_STEP  = 1,
  parameter int FAST_STEP  = 20,
  parameter int PG_DELAY   = 2400,
  parameter int PG_FALL_MV = 825,
  parameter int PG_RISE_MV = 875
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           en,
  input  logic           supply_ok,
  input  logic           fault_shdn,
  input  logic [4:0]     vid,
  input  logic [MVW-1:0] vsense_mv,
  output logic [MVW-1:0] target_mv,
  output logic [MVW-1:0] ref_mv,
  output logic           fast_mode,
  output logic           pgood
);
  localparam int CW = $clog2(PG_DELAY + 1);
  localparam int XW = MVW + 4;

  function automatic logic [MVW-1:0] decode(input logic [4:0] c);
    int n;
    n = int'(c[3:0]);
    if (n == 15) return '0;
    if (c[4])    return MVW'(925 + 25 * (14 - n));
    return MVW'(1300 + 50 * (14 - n));
  endfunction

  assign target_mv = decode(vid);

  wire run = en && supply_ok;

  logic [MVW-1:0] step, up_gap, dn_gap, ref_nxt;
  assign step   = fast_mode ? MVW'(FAST_STEP) : MVW'(SLOW_STEP);
  assign up_gap = target_mv - ref_mv;
  assign dn_gap = ref_mv - target_mv;

  always_comb begin
    ref_nxt = ref_mv;
    if (ref_mv < target_mv)      ref_nxt = (up_gap <= step) ? target_mv : ref_mv + step;
    else if (ref_mv > target_mv) ref_nxt = (dn_gap <= step) ? target_mv : ref_mv - step;
  end

  wire reached90 = (XW'(ref_mv) * XW'(10)) >= (XW'(target_mv) * XW'(9));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ref_mv    <= '0;
      fast_mode <= 1'b0;
    end else if (!run) begin
      ref_mv    <= '0;
      fast_mode <= 1'b0;
    end else begin
      ref_mv <= ref_nxt;
      if (reached90) fast_mode <= 1'b1;
    end
  end

  wire above = vsense_mv > MVW'(PG_RISE_MV);
  wire below = vsense_mv < MVW'(PG_FALL_MV);
  logic [CW-1:0] dly_cnt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pgood   <= 1'b0;
      dly_cnt <= '0;
    end else if (!run || fault_shdn || below) begin
      pgood   <= 1'b0;
      dly_cnt <= '0;
    end else if (!pgood) begin
      if (!above)                          dly_cnt <= '0;
      else if (dly_cnt == CW'(PG_DELAY-1)) pgood   <= 1'b1;
      else                                 dly_cnt <= dly_cnt + 1'b1;
    end
  end
endmodule

// File: rtl/vid_ref_seq_chk.sv
module vid_ref_seq_chk #(
  parameter int MVW        = 12,
  parameter int FAST_STEP  = 20,
  parameter int PG_FALL_MV = 825
) (
  input logic           clk,
  input logic           rst_n,
  input logic           en,
  input logic           supply_ok,
  input logic           fault_shdn,
  input logic [MVW-1:0] vsense_mv,
  input logic [MVW-1:0] target_mv,
  input logic [MVW-1:0] ref_mv,
  input logic           fast_mode,
  input logic           pgood
);
  wire run = en && supply_ok;

  AST_RISE_NO_OVERSHOOT: assert property (@(posedge clk) disable iff (!rst_n)
    (ref_mv > $past(ref_mv)) |-> (ref_mv <= $past(target_mv))); // R6
  AST_FALL_NO_UNDERSHOOT: assert property (@(posedge clk) disable iff (!rst_n)
    (run && $past(run) && ref_mv < $past(ref_mv)) |-> (ref_mv >= $past(target_mv))); // R6
  AST_STEP_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
    (run && $past(run)) |-> ((ref_mv >= $past(ref_mv)) ? (ref_mv - $past(ref_mv) <= MVW'(FAST_STEP))
                                                       : ($past(ref_mv) - ref_mv <= MVW'(FAST_STEP)))); // R5
  AST_OFF_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
    !run |=> (ref_mv == '0 && !fast_mode)); // R7
  AST_FAST_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
    (fast_mode && run) |=> fast_mode); // R5
  AST_FAULT_DROPS_PG: assert property (@(posedge clk) disable iff (!rst_n)
    (fault_shdn || !run) |=> !pgood); // R10
  AST_UNDERVOLT_DROPS_PG: assert property (@(posedge clk) disable iff (!rst_n)
    (vsense_mv < MVW'(PG_FALL_MV)) |=> !pgood); // R9
endmodule

bind vid_ref_seq vid_ref_seq_chk #(.MVW(MVW), .FAST_STEP(FAST_STEP), .PG_FALL_MV(PG_FALL_MV)) u_chk (
  .clk(clk), .rst_n(rst_n), .en(en), .supply_ok(supply_ok), .fault_shdn(fault_shdn),
  .vsense_mv(vsense_mv), .target_mv(target_mv), .ref_mv(ref_mv),
  .fast_mode(fast_mode), .pgood(pgood));

// File: tb/sim_vid_ref_seq.sv
`timescale 1ns/1ps
module sim_vid_ref_seq;
  localparam int MVW = 12, SLOW = 2, FAST = 40, DLY = 16;

  logic clk = 0, rst_n = 0, en = 0, supply_ok = 0, fault_shdn = 0;
  logic [4:0] vid = 5'b11111;
  logic [MVW-1:0] vsense_mv = '0;
  logic [MVW-1:0] target_mv, ref_mv;
  logic fast_mode, pgood;
  int n_run = 0, n_fail = 0;
  int m_ref = 0;
  bit m_fast = 0;

  always #2.5 clk = ~clk;

  vid_ref_seq #(.MVW(MVW), .SLOW_STEP(SLOW), .FAST_STEP(FAST), .PG_DELAY(DLY)) u0 (
    .clk(clk), .rst_n(rst_n), .en(en), .supply_ok(supply_ok), .fault_shdn(fault_shdn),
    .vid(vid), .vsense_mv(vsense_mv), .target_mv(target_mv), .ref_mv(ref_mv),
    .fast_mode(fast_mode), .pgood(pgood));

  function automatic int exp_target(input logic [4:0] c);
    if (c[3:0] == 4'hF) return 0;
    return c[4] ? 925 + 25 * (14 - int'(c[3:0])) : 1300 + 50 * (14 - int'(c[3:0]));
  endfunction

  task automatic check(input string req, input int act, input int exp);
    n_run++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  // one rising edge; model from R4..R7 stepped with the inputs seen at that edge
  task automatic tick();
    int tgt, st;
    bit nf;
    @(posedge clk);
    tgt = exp_target(vid);
    if (!(en && supply_ok)) begin
      m_ref = 0; m_fast = 0;
    end else begin
      nf = m_fast || (m_ref * 10 >= tgt * 9);
      st = m_fast ? FAST : SLOW;
      if (m_ref < tgt)      m_ref = (tgt - m_ref <= st) ? tgt : m_ref + st;
      else if (m_ref > tgt) m_ref = (m_ref - tgt <= st) ? tgt : m_ref - st;
      m_fast = nf;
    end
    @(negedge clk);
  endtask

  // run n ticks and compare the model every tick; one check per call
  task automatic track(input string req, input int n);
    int bad = 0, a = 0, e = 0;
    for (int i = 0; i < n; i++) begin
      tick();
      if (int'(ref_mv) != m_ref || fast_mode != m_fast) begin
        if (bad == 0) begin a = int'(ref_mv) * 2 + fast_mode; e = m_ref * 2 + m_fast; end
        bad++;
      end
    end
    check(req, a, e);
  endtask

  task automatic t_reset();
    check("R7 reset ref", int'(ref_mv), 0);
    check("R7 reset fast", fast_mode, 0);
    check("R10 reset pgood", pgood, 0);
  endtask

  task automatic t_decode();
    int bad1 = 0, bad2 = 0;
    for (int c = 0; c < 32; c++) begin
      vid = 5'(c); #1;
      if (c[3:0] != 4'hF) begin
        if (c[4] && int'(target_mv) != exp_target(5'(c))) bad1++;
        if (!c[4] && int'(target_mv) != exp_target(5'(c))) bad2++;
      end
    end
    check("R1 low range codes", bad1, 0);
    check("R2 high range codes", bad2, 0);
    vid = 5'b11110; #1; check("R1 code 11110", int'(target_mv), 925);
    vid = 5'b00000; #1; check("R2 code 00000", int'(target_mv), 2000);
    vid = 5'b11111; #1; check("R3 code 11111", int'(target_mv), 0);
    vid = 5'b01111; #1; check("R3 code 01111", int'(target_mv), 0);
    @(negedge clk);
  endtask

  task automatic t_startup();
    vid = 5'b01010; en = 1; supply_ok = 1;
    tick();
    check("R4 first slow step", int'(ref_mv), SLOW);
    track("R4 slow ramp", 670);
    check("R4 still slow before 90pct", fast_mode, 0);
    track("R5 switch at 90pct", 30);
    check("R5 fast mode on", fast_mode, 1);
    track("R6 settle on 1500", 20);
    check("R6 exact target up", int'(ref_mv), 1500);
  endtask

  task automatic t_change();
    vid = 5'b10110;
    track("R5 fast ramp down", 40);
    check("R6 exact target down", int'(ref_mv), 1125);
    vid = 5'b00000;
    track("R5 fast ramp up", 40);
    check("R6 exact 2000", int'(ref_mv), 2000);
    vid = 5'b11111;
    track("R3 ramp to off", 60);
    check("R3 ref at 0", int'(ref_mv), 0);
  endtask

  task automatic t_disable();
    vid = 5'b01010;
    track("R5 rise again", 30);
    en = 0; tick();
    check("R7 en low ref", int'(ref_mv), 0);
    check("R7 en low fast", fast_mode, 0);
    en = 1; tick();
    check("R7 restart slow", int'(ref_mv), SLOW);
    track("R7 restart ramp", 40);
    supply_ok = 0; tick();
    check("R7 undervoltage ref", int'(ref_mv), 0);
    supply_ok = 1; tick();
    check("R7 undervoltage restart", int'(ref_mv), SLOW);
  endtask

  task automatic t_pgood();
    vsense_mv = 900;
    for (int i = 0; i < DLY - 1; i++) tick();
    check("R8 pgood before delay", pgood, 0);
    tick(); check("R8 pgood after delay", pgood, 1);
    vsense_mv = 825; for (int i = 0; i < 5; i++) tick();
    check("R9 hold in band", pgood, 1);
    vsense_mv = 824; tick(); check("R9 fall below", pgood, 0);
    vsense_mv = 875; for (int i = 0; i < DLY + 4; i++) tick();
    check("R8 875 not above", pgood, 0);
    vsense_mv = 900; for (int i = 0; i < 10; i++) tick();
    vsense_mv = 850; tick();
    vsense_mv = 900; for (int i = 0; i < DLY - 1; i++) tick();
    check("R8 count restarted", pgood, 0);
    tick(); check("R8 rise after restart", pgood, 1);
    fault_shdn = 1; tick(); check("R10 fault drops", pgood, 0);
    fault_shdn = 0; for (int i = 0; i < DLY - 1; i++) tick();
    check("R10 delay restarts", pgood, 0);
    tick(); check("R10 back after delay", pgood, 1);
    en = 0; tick(); check("R10 disable drops", pgood, 0);
    en = 1;
  endtask

  initial begin
    repeat (3) @(negedge clk);
    t_reset();
    rst_n = 1; @(negedge clk);
    t_decode();
    t_startup();
    t_change();
    t_disable();
    t_pgood();
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    n_run++; n_fail++;
    $display("FAIL watchdog actual=timeout expected=done");
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule